// File: doc/BRIEF.md
# Dual-Mode Threshold Comparator Bank

This block holds a bank of digital comparator channels. Each channel watches a stream of 12-bit conversion results, where one result per channel arrives in each frame. Every channel keeps a running average of its four most recent results. It compares either the raw result or that average against an upper and a lower limit. The comparison runs in one of two modes:

- **Hysteresis mode** behaves like a Schmitt trigger.
- **Window mode** flags any value outside the band between the limits.

Each accepted result can change the channel's output bit. A change raises a one-cycle rising or falling event and a shared interrupt pulse.

Limits, mode and input selection are presented as live register values. The bank copies them into shadow copies only when a frame-start strobe arrives, so a host may rewrite them at any time during a frame. A common-limit switch makes every channel use channel 0's limits. A per-channel clear request is held pending and empties that channel's averaging history at the next frame start.

Top module: `thrcmp_bank`

## Requirements
- R1: Once a channel holds four or more results, `avg_val` for that channel is the floor of the sum of its four most recent results divided by 4. The value is updated on the clock edge that accepts the result.
- R2: After reset or a history clear, `avg_val` is the floor of the sum of the results received so far (1, 2 or 3) divided by that count. With an empty history it reads 0.
- R3: In hysteresis mode (mode bit 0), the output goes to 1 when the compared value is above the upper limit and to 0 when it is below the lower limit. Otherwise it keeps its previous state. The output changes only on the edge that accepts a result for that channel.
- R4: In window mode (mode bit 1), the output is 1 when the compared value is above the upper limit or below the lower limit, and 0 otherwise.
- R5: With the select bit at 0 the raw result is compared. With it at 1 the average that includes the new result is compared.
- R6: Comparisons are unsigned and strict, so a value equal to a limit counts as inside the band.
- R7: Limits, mode bit and select bit are taken from the live inputs only on a cycle where `frame_start` is high. Changes made between frame starts have no effect until the next frame start.
- R8: When `common_lim` is high at a frame start, every channel uses channel 0's upper and lower limits for that frame. Each channel keeps its own mode and select bits.
- R9: A pulse on `flt_clr_req[c]` sets `flt_clr_pend[c]`. At the next frame start, the history of channel c is emptied and the pending bit returns to 0.
- R10: A 0-to-1 output change pulses `pos_evt[c]` for one cycle, and a 1-to-0 change pulses `neg_evt[c]`. Each pulse is aligned with the new output value. `cmp_irq` is high exactly when any event pulse is high.
- R11: After reset, all outputs are 0 and the shadow settings are all zero, which means hysteresis mode, raw input and both limits at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_start | input | 1 | Frame boundary strobe; loads shadow settings and applies pending clears |
| smp_vld | input | 1 | A result is present this cycle |
| smp_ch | input | $clog2(NUM_CH) | Channel the result belongs to |
| smp_data | input | DATA_W | Conversion result |
| lim_hi | input | NUM_CH*DATA_W | Live upper limits, channel c at bits [c*DATA_W +: DATA_W] |
| lim_lo | input | NUM_CH*DATA_W | Live lower limits, same packing |
| mode_win | input | NUM_CH | Live mode bit per channel (0 hysteresis, 1 window) |
| use_avg | input | NUM_CH | Live select bit per channel (0 raw, 1 average) |
| common_lim | input | 1 | Live switch: use channel 0's limits everywhere |
| flt_clr_req | input | NUM_CH | Clear-history request pulses |
| flt_clr_pend | output | NUM_CH | Clear requests waiting for the next frame start |
| avg_val | output | NUM_CH*DATA_W | Current average per channel |
| cmp_out | output | NUM_CH | Comparator output per channel |
| pos_evt | output | NUM_CH | Rising-edge event pulses |
| neg_evt | output | NUM_CH | Falling-edge event pulses |
| cmp_irq | output | 1 | High while any event pulse is high |

## Verification
The bench sweeps ramps through both modes and lands exactly on each limit. A design using >= instead of > would flip the output one step early there. It divides partial histories of one, two and three results, where a design that always divides by four reports averages that are too small. It rewrites settings in mid-frame and checks that the old behaviour persists until the frame start; a design that copies settings at once would switch modes early. It also checks that common limits replace only the limits and not the mode, and that a pending clear neither empties the history early nor stays pending after the frame start.

// File: rtl/thrcmp_pkg.sv
package thrcmp_pkg;
  // Averaging window length; the divider in thrcmp_avg is written for 4.
  localparam int unsigned AVG_DEPTH = 4;
  localparam int unsigned CNT_W     = $clog2(AVG_DEPTH + 1);

  typedef enum logic {
    CMP_HYST = 1'b0,
    CMP_WIN  = 1'b1
  } cmp_mode_e;
endpackage

// File: rtl/thrcmp_rst_sync.sv
module thrcmp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/thrcmp_avg.sv
module thrcmp_avg
  import thrcmp_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              smp_en,
  input  logic [DATA_W-1:0] smp,
  output logic [DATA_W-1:0] avg_nxt,
  output logic [DATA_W-1:0] avg_q
);
  localparam int unsigned SUM_W = DATA_W + $clog2(AVG_DEPTH);

  logic [AVG_DEPTH-1:0][DATA_W-1:0] hist_q, hist_d, hist_b;
  logic [CNT_W-1:0]                 cnt_q, cnt_d, cnt_b, cnt_n;
  logic [SUM_W-1:0]                 sum_q, sum_d, sum_b, sum_n;
  logic [DATA_W-1:0]                avg_d;

  function automatic logic [DATA_W-1:0] div_cnt(input logic [SUM_W-1:0] s,
                                                 input logic [CNT_W-1:0] n);
    logic [SUM_W-1:0] q;
    case (n)
      CNT_W'(1): q = s;
      CNT_W'(2): q = s >> 1;
      CNT_W'(3): q = s / SUM_W'(3);
      default:   q = s >> 2;
    endcase
    return q[DATA_W-1:0];
  endfunction

  // History as seen after an optional clear in this cycle
  always_comb begin
    if (clr) begin
      hist_b = '0;
      cnt_b  = '0;
      sum_b  = '0;
    end else begin
      hist_b = hist_q;
      cnt_b  = cnt_q;
      sum_b  = sum_q;
    end
    sum_n   = sum_b + SUM_W'(smp) - SUM_W'(hist_b[AVG_DEPTH-1]);
    cnt_n   = (cnt_b == CNT_W'(AVG_DEPTH)) ? cnt_b : cnt_b + 1'b1;
    avg_nxt = div_cnt(sum_n, cnt_n);
  end

  always_comb begin
    hist_d = hist_q;
    cnt_d  = cnt_q;
    sum_d  = sum_q;
    avg_d  = avg_q;
    if (smp_en) begin
      hist_d = {hist_b[AVG_DEPTH-2:0], smp};
      cnt_d  = cnt_n;
      sum_d  = sum_n;
      avg_d  = avg_nxt;
    end else if (clr) begin
      hist_d = '0;
      cnt_d  = '0;
      sum_d  = '0;
      avg_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      cnt_q  <= '0;
      sum_q  <= '0;
      avg_q  <= '0;
    end else begin
      hist_q <= hist_d;
      cnt_q  <= cnt_d;
      sum_q  <= sum_d;
      avg_q  <= avg_d;
    end
  end
endmodule

// File: rtl/thrcmp_chan.sv
module thrcmp_chan
  import thrcmp_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              clr_req,
  input  logic              smp_en,
  input  logic [DATA_W-1:0] smp,
  input  logic [DATA_W-1:0] live_hi,
  input  logic [DATA_W-1:0] live_lo,
  input  logic              live_win,
  input  logic              live_avg,
  output logic [DATA_W-1:0] avg_val,
  output logic              cmp_out,
  output logic              pos_evt,
  output logic              neg_evt,
  output logic              clr_pend
);
  logic [DATA_W-1:0] act_hi_q, act_hi_d, act_lo_q, act_lo_d;
  cmp_mode_e         act_mode_q, act_mode_d;
  logic              act_avg_q, act_avg_d;
  logic              pend_d, out_d, pos_d, neg_d;
  logic              clr_now, above, below;
  logic [DATA_W-1:0] avg_nxt, cmp_val;

  // Shadow settings load at the frame boundary; a sample in that cycle sees them
  always_comb begin
    act_hi_d   = act_hi_q;
    act_lo_d   = act_lo_q;
    act_mode_d = act_mode_q;
    act_avg_d  = act_avg_q;
    if (frame_start) begin
      act_hi_d   = live_hi;
      act_lo_d   = live_lo;
      act_mode_d = cmp_mode_e'(live_win);
      act_avg_d  = live_avg;
    end
  end

  assign clr_now = frame_start & clr_pend;
  assign pend_d  = (clr_pend & ~frame_start) | clr_req;

  thrcmp_avg #(.DATA_W(DATA_W)) u_avg (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_now),
    .smp_en  (smp_en),
    .smp     (smp),
    .avg_nxt (avg_nxt),
    .avg_q   (avg_val)
  );

  always_comb begin
    cmp_val = act_avg_d ? avg_nxt : smp;
    above   = cmp_val > act_hi_d;
    below   = cmp_val < act_lo_d;
    out_d   = cmp_out;
    if (smp_en) begin
      if (act_mode_d == CMP_WIN) out_d = above | below;
      else if (above)            out_d = 1'b1;
      else if (below)            out_d = 1'b0;
    end
    pos_d = out_d & ~cmp_out;
    neg_d = ~out_d & cmp_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_hi_q   <= '0;
      act_lo_q   <= '0;
      act_mode_q <= CMP_HYST;
      act_avg_q  <= 1'b0;
      clr_pend   <= 1'b0;
      cmp_out    <= 1'b0;
      pos_evt    <= 1'b0;
      neg_evt    <= 1'b0;
    end else begin
      act_hi_q   <= act_hi_d;
      act_lo_q   <= act_lo_d;
      act_mode_q <= act_mode_d;
      act_avg_q  <= act_avg_d;
      clr_pend   <= pend_d;
      cmp_out    <= out_d;
      pos_evt    <= pos_d;
      neg_evt    <= neg_d;
    end
  end
endmodule

// File: rtl/thrcmp_bank.sv
module thrcmp_bank
  import thrcmp_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned DATA_W = 12,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_start,
  input  logic                     smp_vld,
  input  logic [CH_W-1:0]          smp_ch,
  input  logic [DATA_W-1:0]        smp_data,
  input  logic [NUM_CH*DATA_W-1:0] lim_hi,
  input  logic [NUM_CH*DATA_W-1:0] lim_lo,
  input  logic [NUM_CH-1:0]        mode_win,
  input  logic [NUM_CH-1:0]        use_avg,
  input  logic                     common_lim,
  input  logic [NUM_CH-1:0]        flt_clr_req,
  output logic [NUM_CH-1:0]        flt_clr_pend,
  output logic [NUM_CH*DATA_W-1:0] avg_val,
  output logic [NUM_CH-1:0]        cmp_out,
  output logic [NUM_CH-1:0]        pos_evt,
  output logic [NUM_CH-1:0]        neg_evt,
  output logic                     cmp_irq
);
  logic rst_n_int;

  thrcmp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] hi_sel, lo_sel;
    logic              en;

    assign hi_sel = common_lim ? lim_hi[DATA_W-1:0] : lim_hi[c*DATA_W +: DATA_W];
    assign lo_sel = common_lim ? lim_lo[DATA_W-1:0] : lim_lo[c*DATA_W +: DATA_W];
    assign en     = smp_vld && (smp_ch == CH_W'(c));

    thrcmp_chan #(.DATA_W(DATA_W)) u_chan (
      .clk         (clk),
      .rst_n       (rst_n_int),
      .frame_start (frame_start),
      .clr_req     (flt_clr_req[c]),
      .smp_en      (en),
      .smp         (smp_data),
      .live_hi     (hi_sel),
      .live_lo     (lo_sel),
      .live_win    (mode_win[c]),
      .live_avg    (use_avg[c]),
      .avg_val     (avg_val[c*DATA_W +: DATA_W]),
      .cmp_out     (cmp_out[c]),
      .pos_evt     (pos_evt[c]),
      .neg_evt     (neg_evt[c]),
      .clr_pend    (flt_clr_pend[c])
    );
  end

  assign cmp_irq = |(pos_evt | neg_evt);
endmodule

// File: rtl/thrcmp_chk.sv
module thrcmp_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              smp_vld,
  input logic [NUM_CH-1:0] flt_clr_req,
  input logic [NUM_CH-1:0] flt_clr_pend,
  input logic [NUM_CH-1:0] cmp_out,
  input logic [NUM_CH-1:0] pos_evt,
  input logic [NUM_CH-1:0] neg_evt,
  input logic              cmp_irq
);
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(smp_vld) |-> $stable(cmp_out));

  p_pos_new_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_evt & ~cmp_out) == '0);

  p_pos_old_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_evt & $past(cmp_out)) == '0);

  p_neg_new_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_evt & cmp_out) == '0);

  p_neg_old_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_evt & ~$past(cmp_out)) == '0);

  p_one_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pos_evt | neg_evt) <= 1);

  p_irq_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_irq |-> $past(smp_vld));

  p_pend_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_start) |-> (flt_clr_pend & ~$past(flt_clr_req)) == '0);

  p_pend_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_start) |-> ($past(flt_clr_pend) & ~flt_clr_pend) == '0);
endmodule

bind thrcmp_bank thrcmp_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_start  (frame_start),
  .smp_vld      (smp_vld),
  .flt_clr_req  (flt_clr_req),
  .flt_clr_pend (flt_clr_pend),
  .cmp_out      (cmp_out),
  .pos_evt      (pos_evt),
  .neg_evt      (neg_evt),
  .cmp_irq      (cmp_irq)
);

// File: tb/tb_thrcmp_bank.sv
`timescale 1ns/1ps
module tb_thrcmp_bank;
  localparam int NC = 4;
  localparam int DW = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            frame_start = 1'b0;
  logic            smp_vld = 1'b0;
  logic [1:0]      smp_ch = '0;
  logic [DW-1:0]   smp_data = '0;
  logic [NC*DW-1:0] lim_hi = '0;
  logic [NC*DW-1:0] lim_lo = '0;
  logic [NC-1:0]   mode_win = '0;
  logic [NC-1:0]   use_avg = '0;
  logic            common_lim = 1'b0;
  logic [NC-1:0]   flt_clr_req = '0;
  logic [NC-1:0]   flt_clr_pend;
  logic [NC*DW-1:0] avg_val;
  logic [NC-1:0]   cmp_out, pos_evt, neg_evt;
  logic            cmp_irq;

  thrcmp_bank #(.NUM_CH(NC), .DATA_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .smp_vld(smp_vld),
    .smp_ch(smp_ch), .smp_data(smp_data), .lim_hi(lim_hi), .lim_lo(lim_lo),
    .mode_win(mode_win), .use_avg(use_avg), .common_lim(common_lim),
    .flt_clr_req(flt_clr_req), .flt_clr_pend(flt_clr_pend), .avg_val(avg_val),
    .cmp_out(cmp_out), .pos_evt(pos_evt), .neg_evt(neg_evt), .cmp_irq(cmp_irq)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  // Reference state
  int m_hist[NC][4];
  int m_cnt[NC];
  int m_avg[NC];
  bit [NC-1:0] m_out;
  int a_hi[NC];
  int a_lo[NC];
  bit a_win[NC];
  bit a_avg[NC];
  bit m_pend[NC];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int c, input int hi, input int lo, input bit win, input bit avg);
    lim_hi[c*DW +: DW] = DW'(hi);
    lim_lo[c*DW +: DW] = DW'(lo);
    mode_win[c] = win;
    use_avg[c]  = avg;
  endtask

  task automatic do_frame();
    @(negedge clk);
    frame_start = 1'b1;
    for (int c = 0; c < NC; c++) begin
      a_hi[c]  = common_lim ? int'(lim_hi[DW-1:0]) : int'(lim_hi[c*DW +: DW]);
      a_lo[c]  = common_lim ? int'(lim_lo[DW-1:0]) : int'(lim_lo[c*DW +: DW]);
      a_win[c] = mode_win[c];
      a_avg[c] = use_avg[c];
      if (m_pend[c]) begin
        m_pend[c] = 1'b0;
        m_cnt[c]  = 0;
        m_avg[c]  = 0;
        for (int k = 0; k < 4; k++) m_hist[c][k] = 0;
      end
    end
    @(negedge clk);
    frame_start = 1'b0;
    chk("R9", "pending after frame", int'(flt_clr_pend), 0);
    for (int c = 0; c < NC; c++)
      chk("R9", "average after frame", int'(avg_val[c*DW +: DW]), m_avg[c]);
  endtask

  task automatic req_clr(input int c);
    @(negedge clk);
    flt_clr_req[c] = 1'b1;
    @(negedge clk);
    flt_clr_req[c] = 1'b0;
    m_pend[c] = 1'b1;
    chk("R9", "pending set", int'(flt_clr_pend[c]), 1);
  endtask

  task automatic smp(input int c, input int d, input string tag);
    int sum, v;
    bit nout, old;
    logic [NC-1:0] ep, en;
    @(negedge clk);
    smp_vld  = 1'b1;
    smp_ch   = 2'(c);
    smp_data = DW'(d);
    for (int k = 3; k > 0; k--) m_hist[c][k] = m_hist[c][k-1];
    m_hist[c][0] = d;
    if (m_cnt[c] < 4) m_cnt[c]++;
    sum = 0;
    for (int k = 0; k < m_cnt[c]; k++) sum += m_hist[c][k];
    m_avg[c] = sum / m_cnt[c];
    v = a_avg[c] ? m_avg[c] : d;
    old = m_out[c];
    if (a_win[c])        nout = (v > a_hi[c]) || (v < a_lo[c]);
    else if (v > a_hi[c]) nout = 1'b1;
    else if (v < a_lo[c]) nout = 1'b0;
    else                  nout = old;
    m_out[c] = nout;
    ep = '0; en = '0;
    ep[c] = nout & ~old;
    en[c] = ~nout & old;
    @(negedge clk);
    smp_vld = 1'b0;
    chk((m_cnt[c] < 4) ? "R2" : "R1", "average", int'(avg_val[c*DW +: DW]), m_avg[c]);
    chk(tag, "comparator outputs", int'(cmp_out), int'(m_out));
    chk("R10", "rising events", int'(pos_evt), int'(ep));
    chk("R10", "falling events", int'(neg_evt), int'(en));
    chk("R10", "interrupt", int'(cmp_irq), int'(|(ep | en)));
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin
      m_cnt[c] = 0; m_avg[c] = 0; a_hi[c] = 0; a_lo[c] = 0;
      a_win[c] = 0; a_avg[c] = 0; m_pend[c] = 0;
      for (int k = 0; k < 4; k++) m_hist[c][k] = 0;
    end
    m_out = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    chk("R11", "cmp_out", int'(cmp_out), 0);
    chk("R11", "avg_val", int'(|avg_val), 0);
    chk("R11", "events", int'(pos_evt | neg_evt), 0);
    chk("R11", "irq", int'(cmp_irq), 0);
    chk("R11", "pending", int'(flt_clr_pend), 0);
    // R11: zero shadow limits, hysteresis: any nonzero value drives the output high
    smp(3, 1, "R11");

    // R1 / R2: averaging with unreachable limits, including the /3 step
    set_cfg(1, 4095, 0, 1'b0, 1'b0);
    do_frame();
    begin
      int x = 123;
      for (int i = 0; i < 12; i++) begin
        x = (x * 1103 + 4271) % 4096;
        smp(1, x, "R1");
      end
    end

    // R3 / R6: hysteresis ramp on channel 0
    set_cfg(0, 2000, 1000, 1'b0, 1'b0);
    do_frame();
    for (int d = 0; d < 4096; d += 61) smp(0, d, "R3");
    for (int d = 4095; d >= 0; d -= 61) smp(0, d, "R3");
    smp(0, 2000, "R6");
    smp(0, 2001, "R6");
    smp(0, 1000, "R6");
    smp(0, 1500, "R3");
    smp(0, 999, "R6");

    // R4 / R6: window ramp on channel 2
    set_cfg(2, 3000, 500, 1'b1, 1'b0);
    do_frame();
    for (int d = 0; d < 4096; d += 97) smp(2, d, "R4");
    for (int d = 4095; d >= 0; d -= 97) smp(2, d, "R4");
    smp(2, 3000, "R6");
    smp(2, 3001, "R4");
    smp(2, 500, "R6");
    smp(2, 499, "R4");
    smp(2, 1000, "R4");

    // R5: averaged input on channel 3
    set_cfg(3, 1500, 1400, 1'b0, 1'b1);
    do_frame();
    smp(3, 4000, "R5");
    smp(3, 0, "R5");
    smp(3, 0, "R5");
    smp(3, 4000, "R5");
    smp(3, 1450, "R5");
    smp(3, 0, "R5");

    // R7: settings rewritten mid-frame take effect at the next frame start
    set_cfg(0, 2000, 1000, 1'b1, 1'b0);
    smp(0, 1500, "R7");
    smp(0, 2500, "R7");
    smp(0, 1500, "R7");
    do_frame();
    smp(0, 1500, "R7");
    smp(0, 2500, "R7");

    // R8: common limits replace limits only
    common_lim = 1'b1;
    smp(2, 2500, "R8");
    do_frame();
    smp(2, 2500, "R8");
    smp(2, 1500, "R8");
    smp(2, 2500, "R8");
    common_lim = 1'b0;
    do_frame();
    smp(2, 2500, "R8");

    // R9: pending clear waits for the frame start
    req_clr(1);
    smp(1, 100, "R9");
    do_frame();
    smp(1, 300, "R9");
    smp(1, 301, "R9");
    smp(1, 302, "R9");
    smp(1, 900, "R9");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule